// File: doc/BRIEF.md
# Indexed-Enable Multi-CPU Interrupt Controller

This block collects level-sensitive interrupt lines and presents them to up to four processors. Software does not write bitmasks. It names a source by writing its number to a set register or to a clear register. This is done for the global enable of a source and for each processor's private mask. A per-source routing word picks which processors a source may reach. For routing purposes the fast-interrupt routing bit of a processor counts the same as its normal one.

Each processor reads an acknowledge register in its own address window. The register returns the lowest-numbered source that is asserted, enabled, unmasked for that processor and routed to it. The value 0x3FF means nothing qualifies. Each processor also sees a cause view of sources 0 to 31. A 32-bit error-cause vector is collapsed into source 4 through a per-processor error mask. Source 96 carries the summary line from the message-signalled doorbell logic and is otherwise an ordinary input. The register bus is a simple 32-bit word bus. A window select picks between the global window and the window of the addressed processor. Reads are combinational.

Top module: `idx_irq_ctrl`

## Requirements
- R1: After reset every global enable is clear, every source is masked for every processor, every routing word reads 0, the global on bit is 0, each task-priority register reads 0, each error mask reads 0, every acknowledge reads 0x3FF and irq_o is 0.
- R2: Global offset 0x000 holds the on bit in bit 0 (read/write) and reads the source count NUM_SRC in bits [11:2]. While the on bit is 0, every irq_o bit is 0 and every acknowledge reads 0x3FF.
- R3: A write of value v to global offset 0x030 sets the enable of source v[9:0]. A write to 0x034 clears it. An index at or above NUM_SRC changes no enable. These registers read 0.
- R4: A write of v to per-CPU offset 0x048 masks source v[9:0] for the addressed processor only. A write to 0x04C unmasks it. An out-of-range index changes nothing.
- R5: The routing word of source n sits at global offset 0x100+4n. Bit c routes to processor c as a normal interrupt and bit 8+c as a fast interrupt. Either bit routes the source, and only these bits are stored and read back.
- R6: A source is pending for processor c when its level, its enable, its unmask for c and either routing bit for c are all 1. irq_o[c] is the on bit ANDed with the OR of c's pending sources.
- R7: Per-CPU offset 0x044 reads the lowest-numbered pending source of that processor in bits [9:0], with bits [31:10] zero, or 0x3FF when none is pending. Reading it changes no state.
- R8: Per-CPU offset 0x010 reads, in bit n, whether source n (n < 32) is pending for that processor, independent of the on bit.
- R9: Global offset 0x020 reads the error-cause input. Per-CPU offset 0xE50 is a 32-bit error mask. For processor c the level of source 4 is the OR of (error cause AND error mask of c), and input line 4 is ignored.
- R10: Per-CPU offset 0x040 is a 4-bit task-priority register that reads back its value and has no effect on selection.
- R11: An access whose address bits [1:0] are not 00 writes nothing and reads 0. Unmapped aligned offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_cpu_win | input | 1 | 0 selects the global window, 1 the per-CPU window |
| bus_cpu | input | 2 | Processor whose window is addressed |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| src_lvl_i | input | NUM_SRC | Level-sensitive source lines |
| err_cause_i | input | 32 | Error-cause vector |
| irq_o | output | NUM_CPU | Interrupt request per processor |

## Verification
The bench targets several corner cases. Out-of-range indices such as 200 with 128 sources are one: a design that truncated the index would clear source 72 instead of ignoring the write. Mask writes from one processor are checked against the other processors, to catch a mask that leaks across windows. A source routed only by its fast bit must still be selected. Error bits must be gated by the per-processor mask, and line 4 must not leak into source 4. Simultaneous pending sources check that the lowest number wins. With the on bit cleared, irq_o and the acknowledge must go quiet while the cause view stays live. A long random phase compares every read and irq_o each cycle against a behavioural model.

// File: rtl/idx_ic_pkg.sv
package idx_ic_pkg;
  localparam int IDX_W = 10;
  localparam logic [IDX_W-1:0] ACK_IDLE = 10'h3FF;

  // global window
  localparam logic [11:0] OFF_CTRL   = 12'h000;
  localparam logic [11:0] OFF_ERR    = 12'h020;
  localparam logic [11:0] OFF_EN_SET = 12'h030;
  localparam logic [11:0] OFF_EN_CLR = 12'h034;
  localparam logic [11:0] OFF_ROUTE  = 12'h100;

  // per-CPU window
  localparam logic [11:0] OFF_CAUSE  = 12'h010;
  localparam logic [11:0] OFF_TPR    = 12'h040;
  localparam logic [11:0] OFF_ACK    = 12'h044;
  localparam logic [11:0] OFF_MSK    = 12'h048;
  localparam logic [11:0] OFF_UNMSK  = 12'h04C;
  localparam logic [11:0] OFF_ERRMSK = 12'hE50;
endpackage

// File: rtl/idx_ic_lowest.sv
module idx_ic_lowest #(
  parameter int WIDTH = 128,
  parameter int OUT_W = 10
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             found_o,
  output logic [OUT_W-1:0] idx_o
);
  // scan from the top so the last hit is the lowest index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = OUT_W'(i);
      end
    end
  end
endmodule

// File: rtl/idx_ic_src_cfg.sv
module idx_ic_src_cfg
  import idx_ic_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int NUM_CPU = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  en_set_i,
  input  logic                                  en_clr_i,
  input  logic [IDX_W-1:0]                      idx_i,
  input  logic                                  route_we_i,
  input  logic [$clog2(NUM_SRC)-1:0]            route_sel_i,
  input  logic [2*NUM_CPU-1:0]                  route_wdata_i,
  output logic [NUM_SRC-1:0]                    en_o,
  output logic [NUM_SRC-1:0][2*NUM_CPU-1:0]     route_o
);
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam logic [IDX_W-1:0] SRC_LIM = IDX_W'(NUM_SRC);

  logic               idx_ok;
  logic [SRC_W-1:0]   sel;
  logic               en_we;
  logic [NUM_SRC-1:0] en_d, en_q;

  assign idx_ok = idx_i < SRC_LIM;
  assign sel    = idx_i[SRC_W-1:0];
  assign en_we  = (en_set_i | en_clr_i) & idx_ok;

  always_comb begin
    en_d = en_q;
    if (en_set_i)      en_d[sel] = 1'b1;
    else if (en_clr_i) en_d[sel] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  // one routing word per source, each with its own write enable
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_route
    logic rt_we;
    assign rt_we = route_we_i & (route_sel_i == SRC_W'(n));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     route_o[n] <= '0;
      else if (rt_we) route_o[n] <= route_wdata_i;
    end
  end

  assign en_o = en_q;

  // R3: clearing by index takes effect on the next cycle
  p_en_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_i && !en_set_i && idx_ok) |=> !en_q[$past(sel)]);

  // R3: an out-of-range index leaves all enables untouched
  p_bad_idx_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_set_i || en_clr_i) && !idx_ok) |=> $stable(en_q));
endmodule

// File: rtl/idx_ic_cpu.sv
module idx_ic_cpu
  import idx_ic_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int ERR_SRC = 4,
  parameter int TPR_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_set_i,
  input  logic               mask_clr_i,
  input  logic               tpr_we_i,
  input  logic               emask_we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [31:0]        wdata_i,
  input  logic               glb_on_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] route_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  input  logic [31:0]        err_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   ack_o,
  output logic [31:0]        cause_o,
  output logic [TPR_W-1:0]   tpr_o,
  output logic [31:0]        emask_o
);
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam logic [IDX_W-1:0] SRC_LIM = IDX_W'(NUM_SRC);

  logic               idx_ok;
  logic [SRC_W-1:0]   sel;
  logic               mask_we;
  logic [NUM_SRC-1:0] mask_d, mask_q;
  logic [TPR_W-1:0]   tpr_d, tpr_q;
  logic [31:0]        emask_d, emask_q;
  logic [NUM_SRC-1:0] lvl_eff, pend;
  logic               found;
  logic [IDX_W-1:0]   low_idx;

  assign idx_ok  = idx_i < SRC_LIM;
  assign sel     = idx_i[SRC_W-1:0];
  assign mask_we = (mask_set_i | mask_clr_i) & idx_ok;

  // next-state
  always_comb begin
    mask_d = mask_q;
    if (mask_set_i)      mask_d[sel] = 1'b1;
    else if (mask_clr_i) mask_d[sel] = 1'b0;
  end
  assign tpr_d   = wdata_i[TPR_W-1:0];
  assign emask_d = wdata_i;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      tpr_q   <= '0;
      emask_q <= '0;
    end else begin
      if (mask_we)    mask_q  <= mask_d;
      if (tpr_we_i)   tpr_q   <= tpr_d;
      if (emask_we_i) emask_q <= emask_d;
    end
  end

  // error vector folds into one summary source
  always_comb begin
    lvl_eff          = lvl_i;
    lvl_eff[ERR_SRC] = |(err_i & emask_q);
  end

  assign pend = lvl_eff & en_i & ~mask_q & route_i;

  idx_ic_lowest #(.WIDTH(NUM_SRC), .OUT_W(IDX_W)) u_low (
    .vec_i  (pend),
    .found_o(found),
    .idx_o  (low_idx)
  );

  assign irq_o   = glb_on_i & (|pend);
  assign ack_o   = (glb_on_i && found) ? low_idx : ACK_IDLE;
  assign cause_o = pend[31:0];
  assign tpr_o   = tpr_q;
  assign emask_o = emask_q;

  // assertion-side helper: sources numbered below the acknowledged one
  logic [NUM_SRC-1:0] below_ack;
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) below_ack[i] = IDX_W'(i) < ack_o;
  end

  // R6: request line and acknowledge agree
  p_irq_matches_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (ack_o != ACK_IDLE));

  // R7: the acknowledged source is pending and nothing lower is
  p_ack_is_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o != ACK_IDLE) |-> (ack_o < SRC_LIM) && pend[ack_o[SRC_W-1:0]]
                            && ((pend & below_ack) == '0));

  // R4: never acknowledge a masked, disabled or unrouted source
  p_ack_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o != ACK_IDLE) |-> !mask_q[ack_o[SRC_W-1:0]] && en_i[ack_o[SRC_W-1:0]]
                            && route_i[ack_o[SRC_W-1:0]]);

  // R4: a mask write by index lands on that source
  p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_set_i && idx_ok) |=> mask_q[$past(sel)]);
endmodule

// File: rtl/idx_irq_ctrl.sv
module idx_irq_ctrl
  import idx_ic_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 128,
  parameter int ERR_SRC = 4,
  parameter int TPR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic                       bus_cpu_win,
  input  logic [$clog2(NUM_CPU)-1:0] bus_cpu,
  input  logic [11:0]                bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_SRC-1:0]         src_lvl_i,
  input  logic [31:0]                err_cause_i,
  output logic [NUM_CPU-1:0]         irq_o
);
  localparam int CPU_W = $clog2(NUM_CPU);
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam logic [IDX_W-1:0] SRC_LIM = IDX_W'(NUM_SRC);
  localparam logic [11:0] ROUTE_END = 12'(256 + 4 * NUM_SRC);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // decode
  logic             aligned, g_acc, c_acc;
  logic             ctrl_we, en_set, en_clr, route_hit, route_we;
  logic [SRC_W-1:0] route_sel;

  assign aligned   = bus_addr[1:0] == 2'b00;
  assign g_acc     = !bus_cpu_win && aligned;
  assign c_acc     = bus_cpu_win && aligned;
  assign ctrl_we   = bus_we && g_acc && (bus_addr == OFF_CTRL);
  assign en_set    = bus_we && g_acc && (bus_addr == OFF_EN_SET);
  assign en_clr    = bus_we && g_acc && (bus_addr == OFF_EN_CLR);
  assign route_hit = g_acc && (bus_addr >= OFF_ROUTE) && (bus_addr < ROUTE_END);
  assign route_we  = bus_we && route_hit;
  assign route_sel = SRC_W'((bus_addr - OFF_ROUTE) >> 2);

  // global on bit
  logic glb_on_d, glb_on_q;
  assign glb_on_d = bus_wdata[0];
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     glb_on_q <= 1'b0;
    else if (ctrl_we) glb_on_q <= glb_on_d;
  end

  // source configuration
  logic [NUM_SRC-1:0]                en_w;
  logic [NUM_SRC-1:0][2*NUM_CPU-1:0] route_w;

  idx_ic_src_cfg #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .en_set_i     (en_set),
    .en_clr_i     (en_clr),
    .idx_i        (bus_wdata[IDX_W-1:0]),
    .route_we_i   (route_we),
    .route_sel_i  (route_sel),
    .route_wdata_i({bus_wdata[8+:NUM_CPU], bus_wdata[0+:NUM_CPU]}),
    .en_o         (en_w),
    .route_o      (route_w)
  );

  // per-CPU slices
  logic [NUM_CPU-1:0][IDX_W-1:0] ack_a;
  logic [NUM_CPU-1:0][31:0]      cause_a, emask_a;
  logic [NUM_CPU-1:0][TPR_W-1:0] tpr_a;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic               c_we;
    logic [NUM_SRC-1:0] rt_c;
    assign c_we = bus_we && c_acc && (bus_cpu == CPU_W'(c));
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_rt
      assign rt_c[n] = route_w[n][c] | route_w[n][NUM_CPU + c];
    end
    idx_ic_cpu #(.NUM_SRC(NUM_SRC), .ERR_SRC(ERR_SRC), .TPR_W(TPR_W)) u_cpu (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .mask_set_i(c_we && (bus_addr == OFF_MSK)),
      .mask_clr_i(c_we && (bus_addr == OFF_UNMSK)),
      .tpr_we_i  (c_we && (bus_addr == OFF_TPR)),
      .emask_we_i(c_we && (bus_addr == OFF_ERRMSK)),
      .idx_i     (bus_wdata[IDX_W-1:0]),
      .wdata_i   (bus_wdata),
      .glb_on_i  (glb_on_q),
      .en_i      (en_w),
      .route_i   (rt_c),
      .lvl_i     (src_lvl_i),
      .err_i     (err_cause_i),
      .irq_o     (irq_o[c]),
      .ack_o     (ack_a[c]),
      .cause_o   (cause_a[c]),
      .tpr_o     (tpr_a[c]),
      .emask_o   (emask_a[c])
    );
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (g_acc) begin
      case (bus_addr)
        OFF_CTRL: bus_rdata = {20'b0, SRC_LIM, 1'b0, glb_on_q};
        OFF_ERR:  bus_rdata = err_cause_i;
        default: begin
          if (route_hit) begin
            bus_rdata[0+:NUM_CPU] = route_w[route_sel][NUM_CPU-1:0];
            bus_rdata[8+:NUM_CPU] = route_w[route_sel][2*NUM_CPU-1:NUM_CPU];
          end
        end
      endcase
    end else if (c_acc) begin
      case (bus_addr)
        OFF_CAUSE:  bus_rdata = cause_a[bus_cpu];
        OFF_TPR:    bus_rdata[TPR_W-1:0] = tpr_a[bus_cpu];
        OFF_ACK:    bus_rdata[IDX_W-1:0] = ack_a[bus_cpu];
        OFF_ERRMSK: bus_rdata = emask_a[bus_cpu];
        default:    bus_rdata = '0;
      endcase
    end
  end

  // R11: a misaligned global write leaves the on bit alone
  p_misaligned_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_we && !bus_cpu_win && (bus_addr[1:0] != 2'b00)) |=> $stable(glb_on_q));

  // R2: with the on bit low no request leaves the block
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!glb_on_q && !$past(ctrl_we)) |-> (irq_o == '0));
endmodule

// File: tb/test_idx_irq_ctrl.sv
`timescale 1ns/1ps
module test_idx_irq_ctrl;
  localparam int NC = 4;
  localparam int NS = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_cpu_win = 1'b0;
  logic [1:0]  bus_cpu = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] src_lvl = '0;
  logic [31:0] err_cause = '0;
  logic [NC-1:0] irq;

  always #10 clk = ~clk;

  idx_irq_ctrl #(.NUM_CPU(NC), .NUM_SRC(NS)) i_idx_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_cpu_win(bus_cpu_win),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_lvl_i(src_lvl), .err_cause_i(err_cause),
    .irq_o(irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  // ---------------- behavioural reference model ----------------
  bit          m_on;
  bit          m_en [NS];
  bit          m_msk[NC][NS];
  logic [31:0] m_rt [NS];
  logic [3:0]  m_tpr[NC];
  logic [31:0] m_em [NC];
  bit          mdl_ok = 0;

  function automatic bit m_lvl(int c, int n);
    if (n == 4) return |(err_cause & m_em[c]);
    return src_lvl[n];
  endfunction

  function automatic bit m_pend(int c, int n);
    return m_lvl(c, n) && m_en[n] && !m_msk[c][n] && (m_rt[n][c] || m_rt[n][8+c]);
  endfunction

  function automatic int m_ack(int c);
    if (!m_on) return 'h3FF;
    for (int n = 0; n < NS; n++) if (m_pend(c, n)) return n;
    return 'h3FF;
  endfunction

  function automatic logic [NC-1:0] m_irq();
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) r[c] = m_ack(c) != 'h3FF;
    return r;
  endfunction

  function automatic logic [31:0] m_rd();
    int a;
    int c;
    logic [31:0] r;
    a = int'(bus_addr);
    c = int'(bus_cpu);
    r = '0;
    if (a % 4 != 0) return '0;
    if (!bus_cpu_win) begin
      if (a == 0) r = (NS << 2) | 32'(m_on);
      else if (a == 'h20) r = err_cause;
      else if (a >= 'h100 && a < 'h100 + 4*NS) r = m_rt[(a - 'h100) / 4];
    end else begin
      if (a == 'h10) begin
        for (int n = 0; n < 32; n++) r[n] = m_pend(c, n);
      end
      else if (a == 'h40) r = 32'(m_tpr[c]);
      else if (a == 'h44) r = 32'(m_ack(c));
      else if (a == 'hE50) r = m_em[c];
    end
    return r;
  endfunction

  function automatic string tag_of();
    int a;
    a = int'(bus_addr);
    if (a % 4 != 0) return "R11";
    if (!bus_cpu_win) begin
      if (a == 0) return "R2";
      if (a == 'h20) return "R9";
      if (a >= 'h100) return "R5";
      return "R3";
    end
    if (a == 'h10) return "R8";
    if (a == 'h40) return "R10";
    if (a == 'h44) return "R7";
    if (a == 'hE50) return "R9";
    return "R4";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0;
      for (int n = 0; n < NS; n++) begin
        m_en[n] = 0;
        m_rt[n] = '0;
        for (int c = 0; c < NC; c++) m_msk[c][n] = 1;
      end
      for (int c = 0; c < NC; c++) begin
        m_tpr[c] = '0;
        m_em[c]  = '0;
      end
      mdl_ok = 1;
    end else if (bus_we && bus_addr[1:0] == 2'b00) begin
      int a;
      int i;
      a = int'(bus_addr);
      i = int'(bus_wdata[9:0]);
      if (!bus_cpu_win) begin
        if (a == 0) m_on = bus_wdata[0];
        else if (a == 'h30 && i < NS) m_en[i] = 1;
        else if (a == 'h34 && i < NS) m_en[i] = 0;
        else if (a >= 'h100 && a < 'h100 + 4*NS) m_rt[(a - 'h100) / 4] = bus_wdata & 32'h0F0F;
      end else begin
        if (a == 'h40) m_tpr[bus_cpu] = bus_wdata[3:0];
        else if (a == 'h48 && i < NS) m_msk[bus_cpu][i] = 1;
        else if (a == 'h4C && i < NS) m_msk[bus_cpu][i] = 0;
        else if (a == 'hE50) m_em[bus_cpu] = bus_wdata;
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare every cycle against the model
  always @(negedge clk) begin
    if (rst_n && mdl_ok) begin
      logic [31:0] er;
      logic [NC-1:0] ei;
      er = m_rd();
      ei = m_irq();
      check(bus_rdata == er, tag_of(), bus_rdata, er);
      check(irq == ei, "R6", 32'(irq), 32'(ei));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(bit win, int cpu, int addr, logic [31:0] data);
    @(negedge clk); #1;
    bus_cpu_win = win; bus_cpu = 2'(cpu); bus_addr = 12'(addr);
    bus_wdata = data; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(bit win, int cpu, int addr, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    bus_we = 1'b0; bus_cpu_win = win; bus_cpu = 2'(cpu); bus_addr = 12'(addr);
    @(negedge clk);
    check(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic irq_chk(logic [NC-1:0] exp, string tag);
    @(negedge clk);
    check(irq == exp, tag, 32'(irq), 32'(exp));
  endtask

  task automatic set_lvl(int n, bit v);
    @(negedge clk); #1;
    src_lvl[n] = v;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd_chk(0, 0, 'h000, 32'h200, "R1");
    rd_chk(1, 0, 'h044, 32'h3FF, "R1");
    rd_chk(0, 0, 'h128, 32'h0, "R1");
    rd_chk(1, 3, 'h040, 32'h0, "R1");
    rd_chk(1, 1, 'hE50, 32'h0, "R1");
    irq_chk(4'b0000, "R1");

    // R2 on bit, R11 misaligned write ignored
    wr(0, 0, 'h000, 1);
    rd_chk(0, 0, 'h000, 32'h201, "R2");
    wr(0, 0, 'h001, 0);
    rd_chk(0, 0, 'h000, 32'h201, "R11");
    rd_chk(0, 0, 'h001, 32'h0, "R11");

    // R5 routing storage
    wr(0, 0, 'h128, 32'hFFFF_FFFF);
    rd_chk(0, 0, 'h128, 32'h0F0F, "R5");
    wr(0, 0, 'h128, 32'h2);
    rd_chk(0, 0, 'h128, 32'h2, "R5");

    // R6/R7 single source to CPU1
    wr(0, 0, 'h030, 10);
    wr(1, 1, 'h04C, 10);
    set_lvl(10, 1);
    irq_chk(4'b0010, "R6");
    rd_chk(1, 1, 'h044, 10, "R7");
    rd_chk(1, 0, 'h044, 32'h3FF, "R6");

    // R5 fast-interrupt bit routes; R7 lowest wins; R8 cause
    wr(0, 0, 'h10C, 32'h200);
    wr(0, 0, 'h030, 3);
    wr(1, 1, 'h04C, 3);
    set_lvl(3, 1);
    rd_chk(1, 1, 'h044, 3, "R5");
    rd_chk(1, 1, 'h010, 32'h408, "R8");

    // R4 mask is per CPU
    wr(1, 1, 'h048, 3);
    rd_chk(1, 1, 'h044, 10, "R4");
    wr(0, 0, 'h10C, 32'h201);
    wr(1, 0, 'h04C, 3);
    rd_chk(1, 0, 'h044, 3, "R4");
    rd_chk(1, 1, 'h044, 10, "R4");

    // R3 clear by index, out-of-range index ignored
    wr(0, 0, 'h220, 32'h2);
    wr(0, 0, 'h030, 72);
    wr(1, 1, 'h04C, 72);
    set_lvl(72, 1);
    wr(0, 0, 'h034, 10);
    rd_chk(1, 1, 'h044, 72, "R3");
    wr(0, 0, 'h034, 200);
    rd_chk(1, 1, 'h044, 72, "R3");
    wr(0, 0, 'h030, 200);
    rd_chk(0, 0, 'h030, 32'h0, "R3");

    // R9 error summary on source 4
    wr(0, 0, 'h110, 32'h4);
    wr(0, 0, 'h030, 4);
    wr(1, 2, 'h04C, 4);
    @(negedge clk); #1 err_cause = 32'h100;
    set_lvl(4, 1);
    rd_chk(1, 2, 'h044, 32'h3FF, "R9");
    irq_chk(4'b0011, "R9");
    wr(1, 2, 'hE50, 32'h100);
    rd_chk(1, 2, 'h044, 4, "R9");
    rd_chk(0, 0, 'h020, 32'h100, "R9");
    rd_chk(1, 2, 'hE50, 32'h100, "R9");
    irq_chk(4'b0111, "R9");

    // R10 task priority has no effect on selection
    wr(1, 2, 'h040, 32'hF);
    rd_chk(1, 2, 'h040, 32'hF, "R10");
    rd_chk(1, 2, 'h044, 4, "R10");

    // R7 source 96, lowest wins then moves up
    wr(0, 0, 'h280, 32'h1);
    wr(0, 0, 'h030, 96);
    wr(1, 0, 'h04C, 96);
    set_lvl(96, 1);
    rd_chk(1, 0, 'h044, 3, "R7");
    set_lvl(3, 0);
    rd_chk(1, 0, 'h044, 96, "R7");

    // R2 on bit off quiets outputs, R8 cause stays live
    wr(0, 0, 'h000, 0);
    irq_chk(4'b0000, "R2");
    rd_chk(1, 0, 'h044, 32'h3FF, "R2");
    rd_chk(1, 2, 'h010, 32'h10, "R8");
    wr(0, 0, 'h000, 1);

    // random phase, checked every cycle by the model
    for (int k = 0; k < 4000; k++) begin
      int op;
      @(negedge clk); #1;
      op = $urandom % 12;
      bus_we = 1'b0;
      bus_cpu = 2'($urandom % 4);
      bus_wdata = $urandom;
      case (op)
        0: begin bus_cpu_win = 0; bus_addr = 12'h030; bus_wdata = $urandom % 160; bus_we = 1; end
        1: begin bus_cpu_win = 0; bus_addr = 12'h034; bus_wdata = $urandom % 160; bus_we = 1; end
        2: begin bus_cpu_win = 1; bus_addr = 12'h048; bus_wdata = $urandom % 160; bus_we = 1; end
        3: begin bus_cpu_win = 1; bus_addr = 12'h04C; bus_wdata = $urandom % 160; bus_we = 1; end
        4: begin bus_cpu_win = 0; bus_addr = 12'(256 + 4 * ($urandom % NS)); bus_we = 1; end
        5: begin bus_cpu_win = 0; bus_addr = 12'h000; bus_wdata = 32'(($urandom % 5) != 0); bus_we = 1; end
        6: begin bus_cpu_win = 1; bus_addr = (($urandom % 2) != 0) ? 12'hE50 : 12'h040; bus_we = 1; end
        7: src_lvl = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
        8: err_cause = $urandom & $urandom & $urandom;
        9: begin bus_cpu_win = 1'($urandom % 2); bus_addr = 12'(($urandom % 4096) | 1); bus_we = 1; end
        10: begin bus_cpu_win = 1; bus_addr = (($urandom % 2) != 0) ? 12'h044 : 12'h010; end
        default: begin bus_cpu_win = 0; bus_addr = 12'(256 + 4 * ($urandom % NS)); end
      endcase
    end
    @(negedge clk); #1 bus_we = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule